// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines and drives two outputs to a processor core. The first is a vectored request line, `irq_o`. The second is a fast request line, `fiq_o`, which carries no vector. Each channel has an enable bit and a steering bit that sends it to the fast line. Each channel also has a programmable vector address. Software can raise any channel itself through a force register.

Requests on the vectored path are ranked by channel index, with channel 0 the most urgent. The handler reads the vector register over a simple word-addressed register bus. That read returns the vector address of the winning channel and marks the channel as being serviced. The handler then reads the source register to learn the channel number. A write to the vector register ends service.

While a channel is in service, only channels with a lower index can raise `irq_o`. Only one level of service is tracked.

Top module: `vic_top`

## Requirements
- R1: After reset, `irq_o`, `fiq_o` and `rdata_o` are 0, and every register reads 0.
- R2: `irq_o` is 1 one clock after the register state and `req_i` show at least one channel that is pending, enabled and not steered to the fast line. A channel is pending when its `req_i` bit or its force bit is set.
- R3: `fiq_o` is 1 one clock after at least one channel is pending, enabled and has its steering bit set. Such a channel never raises `irq_o`.
- R4: A channel whose enable bit is 0 raises neither output and shows 0 in both masked status registers.
- R5: Each bit of the force register at word 2 acts as a request on the channel with the same index.
- R6: A read of word 6 returns the vector of the lowest-index eligible channel on the vectored path and marks that channel as being serviced.
- R7: A read of word 7 returns the index of the channel in service in bits [4:0], with bit 31 set while a channel is in service, or 0 when no channel is in service.
- R8: When no channel is eligible, a read of word 6 returns the default vector held at word 8 and leaves the service state unchanged.
- R9: While channel k is in service, only eligible channels with an index below k raise `irq_o` or win a vector read.
- R10: Any write to word 6 ends service, so that word 7 reads 0 afterwards.
- R11: The status registers are read-only. Word 3 shows `req_i` OR force for every channel, word 4 shows the enabled pending vectored channels, and word 5 shows the enabled pending fast channels.
- R12: The register map is as follows. Word 0 holds the enables and word 1 the steering bits. Words 32+i hold the vector of channel i. `rdata_o` is loaded on the clock edge where `re_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Interrupt request lines, one per channel |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Vectored interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
Both interrupt outputs are registered. A change on `req_i` therefore shows on `irq_o` or `fiq_o` one edge later. A register write needs its own edge to take effect before that. The bench waits one edge beyond the write edge and samples on the falling edge.

A read returns its data on the edge where `re_i` is high, and the bench samples it at the next falling edge. The service state also changes on that same edge. Any output check that depends on the service ceiling is therefore made only after one further edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned OFF_EN    = 0;
  localparam int unsigned OFF_FSEL  = 1;
  localparam int unsigned OFF_FORCE = 2;
  localparam int unsigned OFF_RAW   = 3;
  localparam int unsigned OFF_IRQST = 4;
  localparam int unsigned OFF_FIQST = 5;
  localparam int unsigned OFF_VECT  = 6;
  localparam int unsigned OFF_SRC   = 7;
  localparam int unsigned OFF_DEF   = 8;
endpackage

// File: rtl/vic_regs.sv
module vic_regs #(
  parameter int unsigned N_CH = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = $clog2(N_CH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] fsel_o,
  output logic [N_CH-1:0] force_o,
  output logic [DW-1:0]   def_o,
  output logic [DW-1:0]   vec_o [N_CH]
);
  localparam int unsigned IDW = $clog2(N_CH);
  localparam logic [AW-1:0] A_EN    = AW'(vic_pkg::OFF_EN);
  localparam logic [AW-1:0] A_FSEL  = AW'(vic_pkg::OFF_FSEL);
  localparam logic [AW-1:0] A_FORCE = AW'(vic_pkg::OFF_FORCE);
  localparam logic [AW-1:0] A_DEF   = AW'(vic_pkg::OFF_DEF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      fsel_o  <= '0;
      force_o <= '0;
      def_o   <= '0;
    end else if (we_i) begin
      if (addr_i == A_EN)    en_o    <= wdata_i[N_CH-1:0];
      if (addr_i == A_FSEL)  fsel_o  <= wdata_i[N_CH-1:0];
      if (addr_i == A_FORCE) force_o <= wdata_i[N_CH-1:0];
      if (addr_i == A_DEF)   def_o   <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_o[g] <= '0;
      else if (we_i && addr_i[AW-1] && addr_i[IDW-1:0] == IDW'(g)) vec_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_CH = 32,
  parameter int unsigned IDW  = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req_i,
  output logic            any_o,
  output logic [IDW-1:0]  idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDW'(i);
    end
    any_o = |req_i;
  end

  always_comb begin
    if (any_o) begin
      AST_WIN_IS_PENDING: assert (req_i[idx_o]); // R6
      AST_WIN_IS_LOWEST: assert ((req_i & ((N_CH'(1) << idx_o) - N_CH'(1))) == '0); // R6
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int unsigned N_CH = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = $clog2(N_CH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int unsigned IDW = $clog2(N_CH);
  localparam logic [AW-1:0] A_EN    = AW'(vic_pkg::OFF_EN);
  localparam logic [AW-1:0] A_FSEL  = AW'(vic_pkg::OFF_FSEL);
  localparam logic [AW-1:0] A_FORCE = AW'(vic_pkg::OFF_FORCE);
  localparam logic [AW-1:0] A_RAW   = AW'(vic_pkg::OFF_RAW);
  localparam logic [AW-1:0] A_IRQST = AW'(vic_pkg::OFF_IRQST);
  localparam logic [AW-1:0] A_FIQST = AW'(vic_pkg::OFF_FIQST);
  localparam logic [AW-1:0] A_VECT  = AW'(vic_pkg::OFF_VECT);
  localparam logic [AW-1:0] A_SRC   = AW'(vic_pkg::OFF_SRC);
  localparam logic [AW-1:0] A_DEF   = AW'(vic_pkg::OFF_DEF);

  logic [N_CH-1:0] en_q, fsel_q, force_q;
  logic [DW-1:0]   def_q;
  logic [DW-1:0]   vec_q [N_CH];
  logic [N_CH-1:0] raw, irq_pend, fiq_pend, ceil, irq_elig;
  logic            win_any;
  logic [IDW-1:0]  win_id;
  logic            act_q;
  logic [IDW-1:0]  act_id_q;
  logic [DW-1:0]   rd_val;

  vic_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .en_o(en_q), .fsel_o(fsel_q), .force_o(force_q), .def_o(def_q), .vec_o(vec_q)
  );

  assign raw      = req_i | force_q;
  assign irq_pend = raw & en_q & ~fsel_q;
  assign fiq_pend = raw & en_q & fsel_q;

  // service ceiling: only strictly more urgent channels pass
  always_comb begin
    for (int i = 0; i < N_CH; i++) ceil[i] = !act_q || (IDW'(i) < act_id_q);
  end
  assign irq_elig = irq_pend & ceil;

  vic_prio #(.N_CH(N_CH), .IDW(IDW)) u_prio (
    .req_i(irq_elig), .any_o(win_any), .idx_o(win_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_elig;
      fiq_o <= |fiq_pend;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      act_id_q <= '0;
    end else if (we_i && addr_i == A_VECT) begin
      act_q    <= 1'b0;
      act_id_q <= '0;
    end else if (re_i && addr_i == A_VECT && win_any) begin
      act_q    <= 1'b1;
      act_id_q <= win_id;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i[AW-1]) rd_val = vec_q[addr_i[IDW-1:0]];
    else begin
      unique case (addr_i)
        A_EN:    rd_val = DW'(en_q);
        A_FSEL:  rd_val = DW'(fsel_q);
        A_FORCE: rd_val = DW'(force_q);
        A_RAW:   rd_val = DW'(raw);
        A_IRQST: rd_val = DW'(irq_pend);
        A_FIQST: rd_val = DW'(fiq_pend);
        A_VECT:  rd_val = win_any ? vec_q[win_id] : def_q;
        A_SRC:   rd_val = {act_q, (DW-1)'(act_id_q)};
        A_DEF:   rd_val = def_q;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end

  AST_NO_EN_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_q) == '0 |-> !irq_o && !fiq_o); // R4
  AST_DEFAULT_VECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_VECT && irq_elig == '0 |=> rdata_o == $past(def_q)); // R8
  AST_EOS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_VECT |=> !act_q); // R10
  AST_CH0_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(act_q && act_id_q == '0) |-> !irq_o); // R9
  AST_FIQ_NOT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_q == fsel_q) |-> !irq_o); // R3
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int unsigned N_CH = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_CH-1:0] req = '0;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, fiq;
  int checks = 0, errors = 0;

  always #2ns clk = ~clk;

  vic_top #(.N_CH(N_CH), .DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // {req, en, fsel, irq, fiq}
  localparam logic [97:0] TBL [7] = '{
    {32'h0000_0010, 32'h0000_0010, 32'h0000_0000, 1'b1, 1'b0},
    {32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1},
    {32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1},
    {32'h0F00_0000, 32'h00F0_0000, 32'h0000_0000, 1'b0, 1'b0},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0},
    {32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); re = 1'b1; addr = AW'(a);
    @(posedge clk); @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(4ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    // R1 reset
    chk(irq == 1'b0 && fiq == 1'b0, "R1 outputs", {30'b0, irq, fiq}, '0);
    chk(rdata == '0, "R1 rdata", rdata, '0);
    rst_n = 1'b1;
    rd(0, d); chk(d == '0, "R1 enable reg", d, '0);
    rd(7, d); chk(d == '0, "R1 source reg", d, '0);

    // R12 vector table and default vector
    for (int i = 0; i < N_CH; i++) wr(32 + i, 32'h1000 + 32'(i) * 16);
    wr(8, 32'hDEAD_0000);
    rd(32 + 9, d); chk(d == 32'h1090, "R12 vector word", d, 32'h1090);
    rd(8, d); chk(d == 32'hDEAD_0000, "R12 default word", d, 32'hDEAD_0000);

    // R2 R3 R4 table walk
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); req = TBL[k][97:66];
      wr(0, TBL[k][65:34]);
      wr(1, TBL[k][33:2]);
      settle();
      chk(irq == TBL[k][1], "R2 irq table", DW'(irq), DW'(TBL[k][1]));
      chk(fiq == TBL[k][0], "R3 fiq table", DW'(fiq), DW'(TBL[k][0]));
    end

    // R6 R9 R7 R10 ceiling and service
    wr(1, '0); wr(0, 32'hFFFF_FFFF);
    @(negedge clk); req = 32'h0000_0088;
    settle();
    rd(6, d); chk(d == 32'h1030, "R6 vector ch3", d, 32'h1030);
    settle();
    chk(irq == 1'b0, "R9 ch3 in service masks ch7", DW'(irq), 0);
    @(negedge clk); req = 32'h0000_0082;
    settle();
    chk(irq == 1'b1, "R9 ch1 above ceiling", DW'(irq), 1);
    rd(7, d); chk(d == 32'h8000_0003, "R7 source", d, 32'h8000_0003);
    wr(6, '0);
    rd(7, d); chk(d == '0, "R10 end of service", d, '0);
    rd(6, d); chk(d == 32'h1010, "R6 vector ch1", d, 32'h1010);
    wr(6, '0);

    // R8 no eligible channel
    @(negedge clk); req = '0;
    settle();
    rd(6, d); chk(d == 32'hDEAD_0000, "R8 default vector", d, 32'hDEAD_0000);
    rd(7, d); chk(d == '0, "R8 service unchanged", d, '0);

    // R3 fast path is not vectored
    wr(1, 32'h4);
    @(negedge clk); req = 32'h4;
    settle();
    chk(fiq == 1'b1 && irq == 1'b0, "R3 steered ch2", {30'b0, irq, fiq}, 32'h1);
    rd(5, d); chk(d == 32'h4, "R11 fast status", d, 32'h4);
    rd(6, d); chk(d == 32'hDEAD_0000, "R3 steered ch2 not vectored", d, 32'hDEAD_0000);

    // R5 force, R4 masking, R11 status
    wr(1, '0);
    @(negedge clk); req = '0;
    wr(2, 32'h20);
    settle();
    chk(irq == 1'b1, "R5 forced ch5", DW'(irq), 1);
    rd(3, d); chk(d == 32'h20, "R11 raw status", d, 32'h20);
    wr(0, 32'hFFFF_FFDF);
    settle();
    chk(irq == 1'b0, "R4 disabled ch5", DW'(irq), 0);
    rd(4, d); chk(d == '0, "R4 masked status", d, '0);
    rd(3, d); chk(d == 32'h20, "R11 raw keeps disabled", d, 32'h20);
    wr(2, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule